// File: doc/BRIEF.md
# Power-Up Interrupt Hold-Off with OTG Line Status

This block watches the chip's power level and the OTG line inputs. When power comes up, it keeps the interrupt-enable qualifier at zero for a programmable number of clock cycles. The nominal setting is half a second. When that window ends, the qualifier opens to all-ones, but only if power is still present. While the qualifier is held low, the interrupt line of the surrounding controller stays quiet, so the host does not see interrupts while the chip settles.

The block also keeps a 16-bit OTG status word built from the VBUS and session levels:

- Bit 5 reports VBUS valid.
- Bit 6 reports session valid.
- Bit 7 reports session end.

Session valid and session end always take opposite values. Whenever the VBUS-valid bit flips, the block emits a one-cycle change pulse. In the same cycle it emits a set mask for the controller's interrupt source register, with bit 15 as the VBUS-change source. A session change updates the status word but raises no event.

Top module: `pwr_otg_monitor`

## Requirements
- R1: While reset is asserted, the qualifier is all zeros, the status word is zero, and the change pulse and set mask are zero.
- R2: A clock edge that samples power high while the block is unpowered makes the qualifier all zeros from that edge and starts the hold-off.
- R3: If power stays high, the qualifier becomes all-ones exactly HOLD_CYC clock edges after the edge that registered power, and not earlier.
- R4: Power sampled high while already powered has no effect: it neither restarts the hold-off nor clears an open qualifier.
- R5: Power sampled low during the hold-off stops it and the qualifier stays zero. A later rise restarts a full HOLD_CYC window.
- R6: Power sampled low after release clears only the powered state. The qualifier stays all-ones until the next power rise.
- R7: Status bit 5 (VBUS valid) equals the VBUS level sampled at the previous clock edge.
- R8: Status bit 6 (session valid) equals the sampled session level, bit 7 (session end) equals its inverse, and every other status bit is zero.
- R9: The change pulse is high for exactly the one cycle after an edge that flips status bit 5. The 32-bit set mask then carries only bit 15 (value 0x00008000) and is zero otherwise.
- R10: An unchanged VBUS level or any session change produces no change pulse and no set-mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_in | input | 1 | Chip power level |
| vbus_in | input | 1 | VBUS valid level from the line |
| sess_in | input | 1 | Session valid level from the line |
| irq_qual | output | QUAL_W | Interrupt-enable qualifier, all zeros or all ones |
| otg_stat | output | 16 | OTG status word |
| vbus_chg | output | 1 | One-cycle VBUS change pulse |
| src_set | output | SRC_W | Interrupt-source set mask (bit 15 = VBUS change) |

## Verification
The power input is tried with four patterns:

- A clean rise held past the window, which shows whether the release lands on the exact edge.
- A drop after release, which separates "clear powered only" from "clear qualifier".
- A drop inside the window followed by a new rise, which shows whether the count resumes or restarts.
- A long high stretch, which exposes any spurious re-arming.

The line inputs are driven with a VBUS toggle in each direction, a held VBUS level and session toggles. Together these separate a true change event from a level echo, and show whether session activity leaks into the event path. A behavioural reference model checks all outputs on every cycle.

// File: rtl/pwr_otg_pkg.sv
package pwr_otg_pkg;

    localparam int STAT_W           = 16;
    localparam int VBUS_BIT         = 5;
    localparam int SVALID_BIT       = 6;
    localparam int SEND_BIT         = 7;
    localparam int VBUS_CHG_SRC_BIT = 15;

    typedef struct packed {
        logic vbus_valid;
        logic sess_valid;
        logic sess_end;
    } otg_line_t;

endpackage

// File: rtl/pwr_holdoff.sv
module pwr_holdoff #(
    parameter int HOLD_CYC = 100_000_000,
    parameter int QUAL_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_in,
    output logic [QUAL_W-1:0] irq_qual
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic             powered;
        logic             hold;
        logic [CNT_W-1:0] left;
        logic             open;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_in) begin
            st_d.powered = 1'b0;
            st_d.hold    = 1'b0;
        end else if (!st_q.powered) begin
            st_d.powered = 1'b1;
            st_d.hold    = 1'b1;
            st_d.open    = 1'b0;
            st_d.left    = LOAD;
        end else if (st_q.hold) begin
            if (st_q.left == '0) begin
                st_d.hold = 1'b0;
                st_d.open = 1'b1;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_qual = {QUAL_W{st_q.open}};

    // R2: a registered power rise mutes the qualifier
    a_r2_rise_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_in && !st_q.powered) |=> (irq_qual == '0));
    // R3: the qualifier only opens while powered
    a_r3_open_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_qual[0]) |-> st_q.powered);
    // R4: staying high keeps the powered state
    a_r4_powered_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_in && st_q.powered) |=> st_q.powered);
    // R5: power loss stops the hold-off window
    a_r5_drop_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_in |=> (!st_q.hold && !st_q.powered));
    // R6: power loss never opens or closes the qualifier
    a_r6_drop_keeps_qual: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_in |=> $stable(irq_qual));

endmodule

// File: rtl/otg_line_status.sv
module otg_line_status
    import pwr_otg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vbus_in,
    input  logic              sess_in,
    output logic [STAT_W-1:0] otg_stat,
    output logic              vbus_chg
);

    typedef struct packed {
        otg_line_t line;
        logic      chg;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d                 = st_q;
        st_d.line.vbus_valid = vbus_in;
        st_d.line.sess_valid = sess_in;
        st_d.line.sess_end   = !sess_in;
        st_d.chg             = (vbus_in != st_q.line.vbus_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        otg_stat             = '0;
        otg_stat[VBUS_BIT]   = st_q.line.vbus_valid;
        otg_stat[SVALID_BIT] = st_q.line.sess_valid;
        otg_stat[SEND_BIT]   = st_q.line.sess_end;
    end

    assign vbus_chg = st_q.chg;

    // R8: session bits are opposite once the first sample is taken
    a_r8_sess_complement: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (otg_stat[SVALID_BIT] != otg_stat[SEND_BIT]));
    // R9: a pulse marks a real flip of VBUS valid
    a_r9_pulse_is_flip: assert property (@(posedge clk) disable iff (!rst_n)
        vbus_chg |-> (otg_stat[VBUS_BIT] != $past(otg_stat[VBUS_BIT])));
    // R10: no pulse means VBUS valid held
    a_r10_quiet_is_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_chg |-> $stable(otg_stat[VBUS_BIT]));

endmodule

// File: rtl/pwr_otg_monitor.sv
module pwr_otg_monitor
    import pwr_otg_pkg::*;
#(
    parameter int HOLD_CYC = 100_000_000,
    parameter int QUAL_W   = 32,
    parameter int SRC_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_in,
    input  logic              vbus_in,
    input  logic              sess_in,
    output logic [QUAL_W-1:0] irq_qual,
    output logic [STAT_W-1:0] otg_stat,
    output logic              vbus_chg,
    output logic [SRC_W-1:0]  src_set
);

    pwr_holdoff #(
        .HOLD_CYC (HOLD_CYC),
        .QUAL_W   (QUAL_W)
    ) u_holdoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_in   (pwr_in),
        .irq_qual (irq_qual)
    );

    otg_line_status u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .vbus_in  (vbus_in),
        .sess_in  (sess_in),
        .otg_stat (otg_stat),
        .vbus_chg (vbus_chg)
    );

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        if (i == VBUS_CHG_SRC_BIT) begin : g_hit
            assign src_set[i] = vbus_chg;
        end else begin : g_zero
            assign src_set[i] = 1'b0;
        end
    end

    // R9: the set mask carries at most one bit
    a_r9_single_src: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_set));

endmodule

// File: tb/tb_pwr_otg_monitor.sv
module tb_pwr_otg_monitor;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr = 1'b0;
    logic        vb = 1'b0;
    logic        ss = 1'b0;
    logic [31:0] qual;
    logic [15:0] stat;
    logic        chg;
    logic [31:0] srcs;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_otg_monitor #(.HOLD_CYC(H), .QUAL_W(32), .SRC_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_in(pwr), .vbus_in(vb), .sess_in(ss),
        .irq_qual(qual), .otg_stat(stat), .vbus_chg(chg), .src_set(srcs)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_pow = 0, m_holding = 0, m_left = 0, m_qual = 0;
    int m_vb = 0, m_sv = 0, m_se = 0, m_chg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pow = 0; m_holding = 0; m_left = 0; m_qual = 0;
            m_vb = 0; m_sv = 0; m_se = 0; m_chg = 0;
        end else begin
            m_chg = (int'(vb) != m_vb) ? 1 : 0;
            m_vb  = int'(vb);
            m_sv  = int'(ss);
            m_se  = ss ? 0 : 1;
            if (!pwr) begin
                m_pow = 0; m_holding = 0;
            end else if (m_pow == 0) begin
                m_pow = 1; m_holding = 1; m_qual = 0; m_left = H;
            end else if (m_holding != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_holding = 0; m_qual = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R3 qualifier", qual, (m_qual != 0) ? 32'hffff_ffff : 32'h0);
            chk("R7 vbus bit", 32'(stat[5]), 32'(m_vb));
            chk("R8 status", {16'h0, stat & 16'hffdf},
                32'((m_sv << 6) | (m_se << 7)));
            chk("R9 pulse", 32'(chg), 32'(m_chg));
            chk("R9 set mask", srcs, (m_chg != 0) ? 32'h0000_8000 : 32'h0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 qual", qual, 32'h0);
        chk("R1 stat", {16'h0, stat}, 32'h0);
        chk("R1 pulse", {31'h0, chg}, 32'h0);
        chk("R1 mask", srcs, 32'h0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1 pwr = 1'b1;
        @(negedge clk);
        chk("R2 mute after rise", qual, 32'h0);
        repeat (H - 1) @(negedge clk);
        chk("R3 not early", qual, 32'h0);
        @(negedge clk);
        chk("R3 release", qual, 32'hffff_ffff);
        repeat (5) @(negedge clk);
        chk("R4 held high no effect", qual, 32'hffff_ffff);
        #1 pwr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 drop keeps qual", qual, 32'hffff_ffff);
        #1 pwr = 1'b1;
        @(negedge clk);
        chk("R2 second rise mutes", qual, 32'h0);
        repeat (2) @(negedge clk);
        #1 pwr = 1'b0;
        repeat (2 * H) @(negedge clk);
        chk("R5 drop in window stays low", qual, 32'h0);
        #1 pwr = 1'b1;
        repeat (H) @(negedge clk);
        chk("R5 full restart not early", qual, 32'h0);
        @(negedge clk);
        chk("R5 full restart release", qual, 32'hffff_ffff);
        #1 vb = 1'b1;
        @(negedge clk);
        chk("R9 rise pulse", {31'h0, chg}, 32'h1);
        chk("R9 rise mask", srcs, 32'h0000_8000);
        chk("R7 vbus set", {31'h0, stat[5]}, 32'h1);
        @(negedge clk);
        chk("R9 one cycle", {31'h0, chg}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R10 held vbus quiet", {31'h0, chg}, 32'h0);
        #1 ss = 1'b1;
        @(negedge clk);
        chk("R10 session quiet", srcs, 32'h0);
        chk("R8 session bits", {30'h0, stat[7:6]}, 32'h1);
        #1 ss = 1'b0;
        @(negedge clk);
        chk("R8 session end", {30'h0, stat[7:6]}, 32'h2);
        #1 vb = 1'b0;
        @(negedge clk);
        chk("R7 vbus clear", {31'h0, stat[5]}, 32'h0);
        chk("R9 fall pulse", {31'h0, chg}, 32'h1);
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule